// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns a decoded operand specifier into the memory address that the operand occupies. It takes the 3-bit addressing mode and 3-bit register field of the operand, the access size, the value of the address register that the register field names, an index register value, and up to two 16-bit extension words that the fetch logic has already collected. It registers the effective address, a flag telling whether the operand lives in memory, and the value the address register must be written with for the auto-stepping modes. The register file, memory port and instruction fetch lie outside the block.

The mode encoding is the one the operand decoder produces: 0 data register, 1 address register, 2 register indirect, 3 indirect with post-step, 4 indirect with pre-step, 5 indirect with 16-bit displacement, 6 indirect with scaled index, 7 absolute or immediate depending on the register field (0 short absolute, 1 long absolute, 4 immediate). For indexed mode the block decodes the packed extension word and drives the index register selector combinationally, so the register file can return the index value in the same cycle. Every request presented with `in_valid` produces exactly one result one clock later.

Top module: `ea_gen`

## Requirements
- R1: Modes 0 and 1, and mode 7 with register field 4, are not memory operands: the result has `is_mem`=0, `wb_en`=0, `illegal`=0 and `ea`=0; all other legal modes give `is_mem`=1.
- R2: Mode 2 gives `ea` equal to the address register value and leaves the register alone (`wb_en`=0).
- R3: Mode 3 gives `ea` equal to the register value and writes back the register plus the size step, where size code 00 (byte) steps 1, 01 (word) steps 2 and 10 (long) steps 4.
- R4: Mode 4 subtracts the size step first; `ea` and the write-back value both equal the decremented register, with wrap-around modulo 2^32.
- R5: Mode 5 gives the register plus the first extension word sign-extended from 16 bits, with `wb_en`=0.
- R6: Mode 6 gives register + sign-extended bits 7..0 + index × scale, where the first extension word holds index kind in bit 15 (1 = address register), index number in bits 14..12, index width in bit 11 (1 = long), scale in bits 10..9 (00 = 1, 01 = 2, 10 = 4) and zero in bit 8; `idx_is_areg` and `idx_reg` reflect bits 15 and 14..12 in the same cycle; `wb_en`=0.
- R7: With bit 11 clear the index is the low 16 bits of the index value sign-extended to 32 bits before scaling.
- R8: Mode 7 register 0 gives the first extension word sign-extended to 32 bits; mode 7 register 1 gives the first word as the upper half and the second word as the lower half.
- R9: Scale code 11, a set bit 8 in indexed mode, mode 7 with register field 2, 3, 5, 6 or 7, or size code 11 in any mode set `illegal`=1 with `is_mem`=0, `wb_en`=0 and `ea`=0.
- R10: Each request yields one result with `out_valid`=1 exactly one cycle later; a cycle without `in_valid` yields `out_valid`=0 the cycle after, and reset clears all registered outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode field |
| regnum | input | 3 | Register field of the operand |
| size | input | 2 | Access size: 00 byte, 01 word, 10 long |
| areg_val | input | 32 | Value of the address register named by `regnum` |
| idx_val | input | 32 | Value of the index register named by `idx_is_areg`/`idx_reg` |
| ext0 | input | 16 | First extension word |
| ext1 | input | 16 | Second extension word |
| idx_is_areg | output | 1 | Index register is an address register (combinational) |
| idx_reg | output | 3 | Index register number (combinational) |
| out_valid | output | 1 | Result present |
| ea | output | 32 | Effective address |
| is_mem | output | 1 | Operand is in memory |
| wb_en | output | 1 | Write `wb_val` back to the address register |
| wb_val | output | 32 | New address register value |
| illegal | output | 1 | Operand specifier cannot be used |

## Verification
The bench concentrates on the size-dependent step of the post- and pre-step modes, including a pre-step from address zero; a design that stepped by a fixed amount, or used the undecremented value as the address, would show a wrong `ea` or write-back value. Indexed mode is driven with a negative long index, a word index whose low half is negative, and each scale; sign-extending the wrong width or applying the scale code as a multiplier would give an address off by a large or doubled amount. Negative 16-bit displacements and short absolute addresses with the top bit set catch zero-extension, and the reserved codes check that an unusable specifier never asserts a memory access or a register write.

// File: rtl/ea_pkg.sv
package ea_pkg;

    // Operand kinds after decoding mode and register field
    typedef enum logic [3:0] {
        EK_DREG,
        EK_AREG,
        EK_IND,
        EK_POST,
        EK_PRE,
        EK_DISP,
        EK_IDX,
        EK_ABSW,
        EK_ABSL,
        EK_IMM,
        EK_BAD
    } ea_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    // Mode field codes that the operand decoder drives
    localparam logic [2:0] MD_DREG = 3'd0;
    localparam logic [2:0] MD_AREG = 3'd1;
    localparam logic [2:0] MD_IND  = 3'd2;
    localparam logic [2:0] MD_POST = 3'd3;
    localparam logic [2:0] MD_PRE  = 3'd4;
    localparam logic [2:0] MD_DISP = 3'd5;
    localparam logic [2:0] MD_IDX  = 3'd6;
    localparam logic [2:0] MD_EXT  = 3'd7;

    // Register field codes under mode 7
    localparam logic [2:0] RX_ABSW = 3'd0;
    localparam logic [2:0] RX_ABSL = 3'd1;
    localparam logic [2:0] RX_IMM  = 3'd4;

endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
    import ea_pkg::*;
(
    input  logic [2:0] mode,
    input  logic [2:0] regnum,
    output ea_kind_e   kind
);

    always_comb begin
        kind = EK_BAD;
        case (mode)
            MD_DREG: kind = EK_DREG;
            MD_AREG: kind = EK_AREG;
            MD_IND:  kind = EK_IND;
            MD_POST: kind = EK_POST;
            MD_PRE:  kind = EK_PRE;
            MD_DISP: kind = EK_DISP;
            MD_IDX:  kind = EK_IDX;
            default: begin
                case (regnum)
                    RX_ABSW: kind = EK_ABSW;
                    RX_ABSL: kind = EK_ABSL;
                    RX_IMM:  kind = EK_IMM;
                    default: kind = EK_BAD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/ea_step_unit.sv
module ea_step_unit
    import ea_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [1:0]    size,
    output logic [AW-1:0] step,
    output logic          size_bad
);

    // Step is one byte shifted left by the size code
    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb begin
        size_bad = 1'b0;
        step     = '0;
        case (acc_size_e'(size))
            SZ_BYTE: step = ONE;
            SZ_WORD: step = ONE << 1;
            SZ_LONG: step = ONE << 2;
            default: size_bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/ea_index_unit.sv
module ea_index_unit #(
    parameter int EW = 16,
    parameter int AW = 32,
    parameter int DW = 8
) (
    input  logic [EW-1:0] ext,
    input  logic [AW-1:0] idx_val,
    output logic [AW-1:0] offset,
    output logic          idx_is_areg,
    output logic [2:0]    idx_reg,
    output logic          fmt_bad
);

    // Field positions inside the packed index extension word
    localparam int KIND_BIT  = EW - 1;
    localparam int REG_HI    = EW - 2;
    localparam int REG_LO    = EW - 4;
    localparam int WIDE_BIT  = EW - 5;
    localparam int SCALE_HI  = EW - 6;
    localparam int SCALE_LO  = EW - 7;
    localparam int ZERO_BIT  = DW;
    localparam int HALF      = AW / 2;

    logic [1:0]    scale_code;
    logic [AW-1:0] disp_sx;
    logic [AW-1:0] idx_sized;
    logic [AW-1:0] idx_scaled;

    assign idx_is_areg = ext[KIND_BIT];
    assign idx_reg     = ext[REG_HI:REG_LO];
    assign scale_code  = ext[SCALE_HI:SCALE_LO];
    assign disp_sx     = {{(AW-DW){ext[DW-1]}}, ext[DW-1:0]};

    assign idx_sized = ext[WIDE_BIT] ? idx_val
                                     : {{(AW-HALF){idx_val[HALF-1]}}, idx_val[HALF-1:0]};

    always_comb begin
        idx_scaled = idx_sized;
        case (scale_code)
            2'b01:   idx_scaled = idx_sized << 1;
            2'b10:   idx_scaled = idx_sized << 2;
            default: idx_scaled = idx_sized;
        endcase
    end

    assign fmt_bad = (scale_code == 2'b11) || ext[ZERO_BIT];
    assign offset  = disp_sx + idx_scaled;

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int EW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    mode,
    input  logic [2:0]    regnum,
    input  logic [1:0]    size,
    input  logic [31:0]   areg_val,
    input  logic [31:0]   idx_val,
    input  logic [15:0]   ext0,
    input  logic [15:0]   ext1,
    output logic          idx_is_areg,
    output logic [2:0]    idx_reg,
    output logic          out_valid,
    output logic [31:0]   ea,
    output logic          is_mem,
    output logic          wb_en,
    output logic [31:0]   wb_val,
    output logic          illegal
);

    localparam int AW = 2 * EW;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] ea;
        logic          is_mem;
        logic          wb_en;
        logic [AW-1:0] wb_val;
        logic          illegal;
    } res_t;

    res_t res_d, res_q;

    ea_kind_e      kind;
    logic [AW-1:0] step;
    logic          size_bad;
    logic [AW-1:0] idx_off;
    logic          fmt_bad;
    logic [AW-1:0] inc_addr;
    logic [AW-1:0] dec_addr;
    logic [AW-1:0] disp_addr;
    logic [AW-1:0] absw_addr;

    ea_mode_dec u_dec (
        .mode   (mode),
        .regnum (regnum),
        .kind   (kind)
    );

    ea_step_unit #(.AW(AW)) u_step (
        .size     (size),
        .step     (step),
        .size_bad (size_bad)
    );

    ea_index_unit #(.EW(EW), .AW(AW), .DW(8)) u_idx (
        .ext         (ext0),
        .idx_val     (idx_val),
        .offset      (idx_off),
        .idx_is_areg (idx_is_areg),
        .idx_reg     (idx_reg),
        .fmt_bad     (fmt_bad)
    );

    assign inc_addr  = areg_val + step;
    assign dec_addr  = areg_val - step;
    assign disp_addr = areg_val + {{(AW-EW){ext0[EW-1]}}, ext0};
    assign absw_addr = {{(AW-EW){ext0[EW-1]}}, ext0};

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid = 1'b1;
            case (kind)
                EK_IND: begin
                    res_d.is_mem = 1'b1;
                    res_d.ea     = areg_val;
                end
                EK_POST: begin
                    res_d.is_mem = 1'b1;
                    res_d.ea     = areg_val;
                    res_d.wb_en  = 1'b1;
                    res_d.wb_val = inc_addr;
                end
                EK_PRE: begin
                    res_d.is_mem = 1'b1;
                    res_d.ea     = dec_addr;
                    res_d.wb_en  = 1'b1;
                    res_d.wb_val = dec_addr;
                end
                EK_DISP: begin
                    res_d.is_mem = 1'b1;
                    res_d.ea     = disp_addr;
                end
                EK_IDX: begin
                    if (fmt_bad) begin
                        res_d.illegal = 1'b1;
                    end else begin
                        res_d.is_mem = 1'b1;
                        res_d.ea     = areg_val + idx_off;
                    end
                end
                EK_ABSW: begin
                    res_d.is_mem = 1'b1;
                    res_d.ea     = absw_addr;
                end
                EK_ABSL: begin
                    res_d.is_mem = 1'b1;
                    res_d.ea     = {ext0, ext1};
                end
                EK_BAD: begin
                    res_d.illegal = 1'b1;
                end
                default: begin
                    res_d.is_mem = 1'b0;
                end
            endcase
            if (size_bad) begin
                res_d.is_mem  = 1'b0;
                res_d.ea      = '0;
                res_d.wb_en   = 1'b0;
                res_d.wb_val  = '0;
                res_d.illegal = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign ea        = res_q.ea;
    assign is_mem    = res_q.is_mem;
    assign wb_en     = res_q.wb_en;
    assign wb_val    = res_q.wb_val;
    assign illegal   = res_q.illegal;

    AST_IND_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MD_IND && size != 2'b11)
        |=> (ea == $past(areg_val) && !wb_en && is_mem)); // R2

    AST_POST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MD_POST && size != 2'b11)
        |=> (wb_en && ea == $past(areg_val) && $countones(wb_val - ea) == 1
             && (wb_val - ea) < 32'd5)); // R3

    AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MD_PRE && size != 2'b11)
        |=> (wb_en && wb_val == ea && $countones($past(areg_val) - ea) == 1
             && ($past(areg_val) - ea) < 32'd5)); // R4

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!is_mem && !wb_en && ea == '0)); // R9

    AST_NOMEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !is_mem) |-> !wb_en); // R1

    AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10

    AST_REQ_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10

endmodule

// File: tb/ea_gen_test.sv
module ea_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [2:0]  regnum = '0;
    logic [1:0]  size = '0;
    logic [31:0] areg_val = '0;
    logic [31:0] idx_val = '0;
    logic [15:0] ext0 = '0;
    logic [15:0] ext1 = '0;
    logic        idx_is_areg;
    logic [2:0]  idx_reg;
    logic        out_valid;
    logic [31:0] ea;
    logic        is_mem;
    logic        wb_en;
    logic [31:0] wb_val;
    logic        illegal;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] ea;
        logic        is_mem;
        logic        wb_en;
        logic [31:0] wb_val;
        logic        illegal;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    ea_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .regnum(regnum), .size(size), .areg_val(areg_val), .idx_val(idx_val),
        .ext0(ext0), .ext1(ext1), .idx_is_areg(idx_is_areg), .idx_reg(idx_reg),
        .out_valid(out_valid), .ea(ea), .is_mem(is_mem), .wb_en(wb_en),
        .wb_val(wb_val), .illegal(illegal)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic exp_t model(input logic [2:0] m, input logic [2:0] r,
                                   input logic [1:0] s, input logic [31:0] b,
                                   input logic [31:0] x, input logic [15:0] e0,
                                   input logic [15:0] e1);
        exp_t o;
        logic [31:0] st;
        logic [31:0] iv;
        o.ea = '0; o.is_mem = 0; o.wb_en = 0; o.wb_val = '0; o.illegal = 0; o.tag = "";
        st = (s == 2'b00) ? 32'd1 : (s == 2'b01) ? 32'd2 : 32'd4;
        case (m)
            3'd2: begin o.is_mem = 1; o.ea = b; end
            3'd3: begin o.is_mem = 1; o.ea = b; o.wb_en = 1; o.wb_val = b + st; end
            3'd4: begin o.is_mem = 1; o.ea = b - st; o.wb_en = 1; o.wb_val = b - st; end
            3'd5: begin o.is_mem = 1; o.ea = b + sx16(e0); end
            3'd6: begin
                if (e0[10:9] == 2'b11 || e0[8]) o.illegal = 1;
                else begin
                    iv = e0[11] ? x : sx16(x[15:0]);
                    o.is_mem = 1;
                    o.ea = b + {{24{e0[7]}}, e0[7:0]} + iv * (32'd1 << e0[10:9]);
                end
            end
            3'd7: begin
                if (r == 3'd0) begin o.is_mem = 1; o.ea = sx16(e0); end
                else if (r == 3'd1) begin o.is_mem = 1; o.ea = {e0, e1}; end
                else if (r != 3'd4) o.illegal = 1;
            end
            default: ;
        endcase
        if (s == 2'b11) begin
            o.ea = '0; o.is_mem = 0; o.wb_en = 0; o.wb_val = '0; o.illegal = 1;
        end
        return o;
    endfunction

    // Driver: presents one request on the next falling edge and queues its expectation
    task automatic send(input logic [2:0] m, input logic [2:0] r, input logic [1:0] s,
                        input logic [31:0] b, input logic [31:0] x,
                        input logic [15:0] e0, input logic [15:0] e1, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; mode = m; regnum = r; size = s;
        areg_val = b; idx_val = x; ext0 = e0; ext1 = e1;
        e = model(m, r, s, b, x, e0, e1);
        e.tag = tag;
        sb.push_back(e);
        if (m == 3'd6) begin
            #1;
            check(idx_is_areg == e0[15] && idx_reg == e0[14:12], "R6 index selector",
                  {28'd0, idx_is_areg, idx_reg}, {28'd0, e0[15], e0[14:12]});
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: samples after each rising edge and compares against the queue head
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10 unexpected result", 32'd1, 32'd0);
                end else begin
                    e = sb.pop_front();
                    check(ea == e.ea, {e.tag, " ea"}, ea, e.ea);
                    check(is_mem == e.is_mem, {e.tag, " is_mem"}, {31'd0, is_mem}, {31'd0, e.is_mem});
                    check(wb_en == e.wb_en, {e.tag, " wb_en"}, {31'd0, wb_en}, {31'd0, e.wb_en});
                    if (e.wb_en)
                        check(wb_val == e.wb_val, {e.tag, " wb_val"}, wb_val, e.wb_val);
                    check(illegal == e.illegal, {e.tag, " illegal"}, {31'd0, illegal}, {31'd0, e.illegal});
                end
            end else if (rst_n && sb.size() != 0) begin
                check(1'b0, "R10 missing result", 32'd0, 32'd1);
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            check(1'b0, "watchdog expired", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(out_valid == 0 && wb_en == 0 && ea == 0, "R10 reset state",
              {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 non-memory operands
        send(3'd0, 3'd2, 2'b10, 32'h1234_5678, 0, 16'h0, 16'h0, "R1 data reg");
        send(3'd1, 3'd3, 2'b01, 32'h0000_7000, 0, 16'h0, 16'h0, "R1 addr reg");
        send(3'd7, 3'd4, 2'b10, 32'h0000_7000, 0, 16'h7800, 16'h0, "R1 immediate");
        // R2 indirect
        send(3'd2, 3'd0, 2'b10, 32'h0000_7060, 0, 16'h0, 16'h0, "R2 indirect");
        // R3 post-step by size
        send(3'd3, 3'd0, 2'b00, 32'h0000_7060, 0, 16'h0, 16'h0, "R3 post byte");
        send(3'd3, 3'd0, 2'b01, 32'h0000_7060, 0, 16'h0, 16'h0, "R3 post word");
        send(3'd3, 3'd0, 2'b10, 32'h0000_7060, 0, 16'h0, 16'h0, "R3 post long");
        // R4 pre-step by size and wrap
        send(3'd4, 3'd0, 2'b10, 32'h0000_7064, 0, 16'h0, 16'h0, "R4 pre long");
        send(3'd4, 3'd0, 2'b00, 32'h0000_7003, 0, 16'h0, 16'h0, "R4 pre byte");
        send(3'd4, 3'd0, 2'b01, 32'h0000_0000, 0, 16'h0, 16'h0, "R4 pre wrap");
        idle(2);
        // R5 displacement
        send(3'd5, 3'd0, 2'b10, 32'h0000_703C, 0, 16'h0024, 16'h0, "R5 disp pos");
        send(3'd5, 3'd0, 2'b10, 32'h0000_7060, 0, 16'hFFFC, 16'h0, "R5 disp neg");
        // R6 indexed: data reg 1, long, scale 1, disp 0xFC
        send(3'd6, 3'd0, 2'b10, 32'h0000_703C, 32'hFFFF_FF00, 16'h18FC, 16'h0, "R6 index neg");
        // data reg 1, long, scale 4, disp 0x24
        send(3'd6, 3'd0, 2'b10, 32'h0000_782C, 32'h0000_0004, 16'h1C24, 16'h0, "R6 index x4");
        // address reg 5, long, scale 2, disp 0
        send(3'd6, 3'd1, 2'b00, 32'h0000_3004, 32'h0000_0003, 16'hDA00, 16'h0, "R6 areg x2");
        // R7 word index, scale 2
        send(3'd6, 3'd0, 2'b01, 32'h0001_0000, 32'h1234_8000, 16'h2201, 16'h0, "R7 word idx neg");
        send(3'd6, 3'd0, 2'b01, 32'h0000_1000, 32'hFFFF_0010, 16'h3000, 16'h0, "R7 word idx pos");
        // R8 absolute
        send(3'd7, 3'd0, 2'b10, 32'hDEAD_BEEF, 0, 16'h7060, 16'h0, "R8 abs short");
        send(3'd7, 3'd0, 2'b10, 32'hDEAD_BEEF, 0, 16'h8000, 16'h0, "R8 abs short neg");
        send(3'd7, 3'd1, 2'b00, 32'hDEAD_BEEF, 0, 16'h0001, 16'h8060, "R8 abs long");
        idle(1);
        // R9 illegal specifiers
        send(3'd6, 3'd0, 2'b10, 32'h0000_7000, 32'h4, 16'h1E10, 16'h0, "R9 scale 11");
        send(3'd6, 3'd0, 2'b10, 32'h0000_7000, 32'h4, 16'h1910, 16'h0, "R9 bit8 set");
        send(3'd7, 3'd5, 2'b10, 32'h0000_7000, 0, 16'h1234, 16'h0, "R9 mode7 reg5");
        send(3'd3, 3'd0, 2'b11, 32'h0000_7000, 0, 16'h0, 16'h0, "R9 size 11");
        idle(3);
        check(sb.size() == 0, "R10 queue drained", sb.size(), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule